// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Port

This block is the host-facing register file of a real-time clock. The host sees two byte addresses: an index address that selects one of 128 byte registers, and a data address that reads or writes the selected register. Most locations are plain storage. Ten of them hold the time, date and alarm bytes. Four control and status registers at offsets 10 to 13 follow access rules of their own.

Control register A holds the rate and oscillator selects, plus a read-only update-in-progress bit. Control register B holds the enables and the SET bit, which freezes time loading. Register C holds the interrupt flags and clears when it is read. Register D is a fixed, read-only status value. The surrounding timekeeping and periodic logic pulse flag inputs into register C, drive the update-in-progress bit, and take the control bits and the time bytes from the exported outputs. A one-cycle `time_load` pulse tells the calendar logic to reload its internal time from the time bytes.

Top module: `rtc_regport`

## Requirements
- R1: A write to the index address (`bus_addr`=0) latches the low 7 bits of `bus_wdata` as the register index. Bit 7 is discarded, so 0x8B selects register 0x0B.
- R2: A read from the index address returns 0xFF.
- R3: After reset, register A reads 0x26, B reads 0x02, C reads 0x00 and D reads 0x80, `irq` is low and `time_load` is low.
- R4: Bit 7 of register A (update in progress) cannot be changed by host writes, which keep its current value. A `uip_set` pulse sets it while SET (B bit 7) is clear. A `uip_clr` pulse clears it, and a clear wins over a set in the same cycle.
- R5: A write to register B with bit 7 high clears A bit 7 and stores B with bit 4 forced to zero.
- R6: Host writes to registers C and D have no effect. C keeps its value, D keeps reading 0x80 and `irq` is unchanged.
- R7: A data read of register C returns its current contents. The register then becomes 0x00 and `irq` drops, unless a flag pulse arrives in the same cycle.
- R8: Each flag pulse sets its own bit in C and also sets C bit 7. The mapping is `flg_per` to bit 6, `flg_alm` to bit 5 and `flg_upd` to bit 4. `irq` rises on the next cycle and stays high until C is read.
- R9: A flag pulse in the same cycle as a C read is not lost. The read returns the old contents, C then holds that flag bit plus bit 7, and `irq` stays high.
- R10: A data write to a time/date register (index 0, 2, 4, 6, 7, 8 or 9) while SET is clear raises `time_load` for exactly the cycle after the write. While SET is high, no pulse is raised.
- R11: A write to register B that takes SET from 1 to 0 raises `time_load` for one cycle. A B write with SET already clear does not.
- R12: Every other location, including the alarm bytes and locations 14 to 127, reads back the last byte written to it.
- R13: `ctrl_a` and `ctrl_b` always show registers A and B. `time_regs` packs the bytes at indices 0, 2, 4, 6, 7, 8 and 9, with index 0 in bits 7:0 and each later byte 8 bits higher.
- R14: A `uip_set` pulse has no effect while SET is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index address, 1 = data address |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, valid while the read strobe is high |
| flg_per | input | 1 | Periodic flag pulse |
| flg_alm | input | 1 | Alarm flag pulse |
| flg_upd | input | 1 | Update-ended flag pulse |
| uip_set | input | 1 | Update-in-progress set pulse |
| uip_clr | input | 1 | Update-in-progress clear pulse |
| irq | output | 1 | Interrupt request (polarity set by parameter) |
| ctrl_a | output | 8 | Current register A |
| ctrl_b | output | 8 | Current register B |
| time_load | output | 1 | One-cycle request to reload the internal time |
| time_regs | output | 56 | Packed time/date bytes |

## Verification
The hardest case to reach is a flag pulse that lands in the same clock edge as the host read of register C. The two events come from independent sources and must be aligned to a single cycle. The bench drives the flag pulse from inside the read cycle itself, so both are sampled at one edge. It then checks three things: the old value returned by the read, `irq` still high afterwards, and the surviving flag in a second read. The SET-exit reload is also reached deliberately: SET is raised, a time byte is written to confirm no reload happens, and SET is then dropped.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
   localparam int unsigned OFS_A = 10;
   localparam int unsigned OFS_B = 11;
   localparam int unsigned OFS_C = 12;
   localparam int unsigned OFS_D = 13;

   localparam int unsigned A_UIP_BIT = 7;
   localparam int unsigned B_SET_BIT = 7;
   localparam int unsigned B_UEN_BIT = 4;

   localparam logic [7:0] A_RESET = 8'h26;
   localparam logic [7:0] B_RESET = 8'h02;
   localparam logic [7:0] D_VALUE = 8'h80;

   // time/date byte locations, in packing order of the time_regs output
   function automatic logic is_time_idx(input logic [7:0] i);
      return (i == 8'd0) || (i == 8'd2) || (i == 8'd4) || (i == 8'd6) ||
             (i == 8'd7) || (i == 8'd8) || (i == 8'd9);
   endfunction

   function automatic logic is_ctrl_idx(input logic [7:0] i);
      return (i >= 8'(OFS_A)) && (i <= 8'(OFS_D));
   endfunction
endpackage

// File: rtl/rtc_index_latch.sv
module rtc_index_latch #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [7:0]        din,
   output logic [ADDR_W-1:0] idx
);
   logic unused_din;
   assign unused_din = ^din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx <= '0;
      else if (load) idx <= din[ADDR_W-1:0];
   end
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
   parameter int ADDR_W = 7,
   localparam int NUM_REGS = 1 << ADDR_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [ADDR_W-1:0]     waddr,
   input  logic [7:0]            wdata,
   output logic [NUM_REGS*8-1:0] bytes_flat
);
   import rtc_regport_pkg::*;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_loc
      if (i >= int'(OFS_A) && i <= int'(OFS_D)) begin : g_ctrl
         // control locations live in rtc_ctrl_regs
         assign bytes_flat[i*8 +: 8] = 8'h00;
      end else begin : g_byte
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= 8'h00;
            else if (we && waddr == ADDR_W'(i))      q <= wdata;
         end
         assign bytes_flat[i*8 +: 8] = q;
      end
   end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_a,
   input  logic       wr_b,
   input  logic       rd_c,
   input  logic [7:0] wdata,
   input  logic       flg_per,
   input  logic       flg_alm,
   input  logic       flg_upd,
   input  logic       uip_set,
   input  logic       uip_clr,
   output logic [7:0] reg_a,
   output logic [7:0] reg_b,
   output logic [7:0] reg_c,
   output logic       irq_q,
   output logic       set_exit
);
   import rtc_regport_pkg::*;

   logic [6:0] a_low;
   logic       uip;
   logic       any_flag;
   logic [7:0] new_flags;

   assign any_flag  = flg_per | flg_alm | flg_upd;
   assign new_flags = {any_flag, flg_per, flg_alm, flg_upd, 4'h0};
   assign set_exit  = wr_b && !wdata[B_SET_BIT] && reg_b[B_SET_BIT];
   assign reg_a     = {uip, a_low};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_low <= A_RESET[6:0];
         uip   <= A_RESET[A_UIP_BIT];
         reg_b <= B_RESET;
         reg_c <= 8'h00;
         irq_q <= 1'b0;
      end else begin
         if (wr_a) a_low <= wdata[6:0];

         if (wr_b) begin
            if (wdata[B_SET_BIT]) reg_b <= wdata & ~(8'h01 << B_UEN_BIT);
            else                  reg_b <= wdata;
         end

         if (wr_b && wdata[B_SET_BIT])        uip <= 1'b0;
         else if (uip_clr)                    uip <= 1'b0;
         else if (uip_set && !reg_b[B_SET_BIT]) uip <= 1'b1;

         if (rd_c) reg_c <= new_flags;
         else      reg_c <= reg_c | new_flags;

         if (any_flag)  irq_q <= 1'b1;
         else if (rd_c) irq_q <= 1'b0;
      end
   end
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport #(
   parameter int ADDR_W         = 7,
   parameter bit IRQ_ACTIVE_LOW = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_en,
   input  logic        bus_wr,
   input  logic        bus_addr,
   input  logic [7:0]  bus_wdata,
   output logic [7:0]  bus_rdata,
   input  logic        flg_per,
   input  logic        flg_alm,
   input  logic        flg_upd,
   input  logic        uip_set,
   input  logic        uip_clr,
   output logic        irq,
   output logic [7:0]  ctrl_a,
   output logic [7:0]  ctrl_b,
   output logic        time_load,
   output logic [55:0] time_regs
);
   import rtc_regport_pkg::*;

   localparam int NUM_REGS = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(OFS_A);
   localparam logic [ADDR_W-1:0] IDX_B = ADDR_W'(OFS_B);
   localparam logic [ADDR_W-1:0] IDX_C = ADDR_W'(OFS_C);
   localparam logic [ADDR_W-1:0] IDX_D = ADDR_W'(OFS_D);

   if (ADDR_W < 4 || ADDR_W > 8) begin : g_bad_width
      $error("rtc_regport: ADDR_W must be 4..8");
   end

   logic [ADDR_W-1:0]     cur_idx;
   logic [NUM_REGS*8-1:0] bytes_flat;
   logic [7:0]            reg_a, reg_b, reg_c;
   logic                  irq_q, set_exit;
   logic                  data_wr, data_rd, idx_wr;
   logic                  store_we, time_load_d;
   logic [7:0]            idx8;

   assign idx8    = 8'(cur_idx);
   assign idx_wr  = bus_en &&  bus_wr && !bus_addr;
   assign data_wr = bus_en &&  bus_wr &&  bus_addr;
   assign data_rd = bus_en && !bus_wr &&  bus_addr;
   assign store_we = data_wr && !is_ctrl_idx(idx8);

   rtc_index_latch #(.ADDR_W(ADDR_W)) u_idx (
      .clk(clk), .rst_n(rst_n), .load(idx_wr), .din(bus_wdata), .idx(cur_idx)
   );

   rtc_byte_store #(.ADDR_W(ADDR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(store_we), .waddr(cur_idx),
      .wdata(bus_wdata), .bytes_flat(bytes_flat)
   );

   rtc_ctrl_regs u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_a(data_wr && cur_idx == IDX_A),
      .wr_b(data_wr && cur_idx == IDX_B),
      .rd_c(data_rd && cur_idx == IDX_C),
      .wdata(bus_wdata),
      .flg_per(flg_per), .flg_alm(flg_alm), .flg_upd(flg_upd),
      .uip_set(uip_set), .uip_clr(uip_clr),
      .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
      .irq_q(irq_q), .set_exit(set_exit)
   );

   always_comb begin
      if (!bus_addr) bus_rdata = 8'hFF;
      else begin
         unique case (cur_idx)
            IDX_A:   bus_rdata = reg_a;
            IDX_B:   bus_rdata = reg_b;
            IDX_C:   bus_rdata = reg_c;
            IDX_D:   bus_rdata = D_VALUE;
            default: bus_rdata = bytes_flat[cur_idx*8 +: 8];
         endcase
      end
   end

   assign time_load_d = (data_wr && is_time_idx(idx8) && !reg_b[B_SET_BIT]) || set_exit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) time_load <= 1'b0;
      else        time_load <= time_load_d;
   end

   assign ctrl_a    = reg_a;
   assign ctrl_b    = reg_b;
   assign time_regs = {bytes_flat[9*8 +: 8], bytes_flat[8*8 +: 8], bytes_flat[7*8 +: 8],
                       bytes_flat[6*8 +: 8], bytes_flat[4*8 +: 8], bytes_flat[2*8 +: 8],
                       bytes_flat[0 +: 8]};

   if (IRQ_ACTIVE_LOW) begin : g_irq_low
      assign irq = ~irq_q;
   end else begin : g_irq_high
      assign irq = irq_q;
   end
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_wr,
   input logic              bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic [ADDR_W-1:0] cur_idx,
   input logic [7:0]        ctrl_a,
   input logic [7:0]        ctrl_b,
   input logic              irq_q,
   input logic              time_load,
   input logic              flg_per,
   input logic              flg_alm,
   input logic              flg_upd,
   input logic              uip_set,
   input logic              uip_clr
);
   import rtc_regport_pkg::*;

   logic dwr, drd, anyf;
   assign dwr  = bus_en &&  bus_wr && bus_addr;
   assign drd  = bus_en && !bus_wr && bus_addr;
   assign anyf = flg_per | flg_alm | flg_upd;

   AST_INDEX_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_wr && !bus_addr) |-> bus_rdata == 8'hFF); // R2

   AST_UIP_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && cur_idx == ADDR_W'(OFS_A) && !uip_set && !uip_clr) |=> ctrl_a[7] == $past(ctrl_a[7])); // R4

   AST_SET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && cur_idx == ADDR_W'(OFS_B) && bus_wdata[7]) |=> (!ctrl_a[7] && !ctrl_b[4])); // R5

   AST_C_WRITE_NO_IRQ_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && cur_idx == ADDR_W'(OFS_C) && !anyf) |=> $stable(irq_q)); // R6

   AST_C_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (drd && cur_idx == ADDR_W'(OFS_C) && !anyf) |=> !irq_q); // R7

   AST_FLAG_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      anyf |=> irq_q); // R8

   AST_NO_LOAD_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && is_time_idx(8'(cur_idx)) && ctrl_b[7]) |=> !time_load); // R10

   AST_UIP_IGNORED_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (uip_set && ctrl_b[7] && !ctrl_a[7]) |=> !ctrl_a[7]); // R14
endmodule

bind rtc_regport rtc_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cur_idx(cur_idx),
   .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .irq_q(irq_q), .time_load(time_load),
   .flg_per(flg_per), .flg_alm(flg_alm), .flg_upd(flg_upd),
   .uip_set(uip_set), .uip_clr(uip_clr)
);

// File: tb/tb_rtc_regport.sv
module tb_rtc_regport;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        flg_per = 1'b0, flg_alm = 1'b0, flg_upd = 1'b0;
   logic        uip_set = 1'b0, uip_clr = 1'b0;
   logic        irq, time_load;
   logic [7:0]  ctrl_a, ctrl_b;
   logic [55:0] time_regs;

   always #4 clk = ~clk; // 125 MHz

   rtc_regport dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flg_per(flg_per), .flg_alm(flg_alm),
      .flg_upd(flg_upd), .uip_set(uip_set), .uip_clr(uip_clr), .irq(irq),
      .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .time_load(time_load), .time_regs(time_regs)
   );

   typedef enum int {K_RDATA, K_IRQ, K_TLOAD, K_CA, K_CB, K_TSEC, K_TMIN} kind_t;
   typedef struct {
      kind_t      kind;
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t exp_q[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   function automatic logic [7:0] actual(kind_t k);
      case (k)
         K_RDATA: return bus_rdata;
         K_IRQ:   return {7'h0, irq};
         K_TLOAD: return {7'h0, time_load};
         K_CA:    return ctrl_a;
         K_CB:    return ctrl_b;
         K_TSEC:  return time_regs[7:0];
         default: return time_regs[15:8];
      endcase
   endfunction

   // monitor: compares everything queued at each sampling point
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (exp_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = exp_q.pop_front();
            act = actual(it.kind);
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic expect_v(kind_t k, logic [7:0] e, string tag);
      item_t it;
      it.kind = k; it.exp = e; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic bus_write(logic a, logic [7:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic sel(logic [7:0] i);
      bus_write(1'b0, i);
   endtask

   task automatic rd(logic a, logic [7:0] e, string tag);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
      expect_v(K_RDATA, e, tag);
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic pulse(int which);
      @(negedge clk);
      case (which)
         0: flg_per = 1'b1;
         1: flg_alm = 1'b1;
         2: flg_upd = 1'b1;
         3: uip_set = 1'b1;
         default: uip_clr = 1'b1;
      endcase
      @(negedge clk);
      flg_per = 1'b0; flg_alm = 1'b0; flg_upd = 1'b0; uip_set = 1'b0; uip_clr = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 reset state
      expect_v(K_IRQ, 8'h00, "R3");
      expect_v(K_TLOAD, 8'h00, "R3");
      sel(8'h0A); rd(1'b1, 8'h26, "R3");
      sel(8'h0B); rd(1'b1, 8'h02, "R3");
      sel(8'h0C); rd(1'b1, 8'h00, "R3");
      sel(8'h0D); rd(1'b1, 8'h80, "R3");
      // R1 index bit 7 discarded
      sel(8'h8B); rd(1'b1, 8'h02, "R1");
      // R2 index address reads 0xFF
      rd(1'b0, 8'hFF, "R2");
      // R12 plain storage
      sel(8'h0E); bus_write(1'b1, 8'h5A); rd(1'b1, 8'h5A, "R12");
      sel(8'h7F); bus_write(1'b1, 8'hC3); rd(1'b1, 8'hC3, "R12");
      sel(8'h01); bus_write(1'b1, 8'h33);
      expect_v(K_TLOAD, 8'h00, "R12");
      rd(1'b1, 8'h33, "R12");
      sel(8'h0E); rd(1'b1, 8'h5A, "R12");
      // R4 read-only update-in-progress bit
      pulse(3);
      sel(8'h0A); rd(1'b1, 8'hA6, "R4");
      bus_write(1'b1, 8'h2F); rd(1'b1, 8'hAF, "R4");
      pulse(4); rd(1'b1, 8'h2F, "R4");
      bus_write(1'b1, 8'hA5); rd(1'b1, 8'h25, "R4");
      expect_v(K_CA, 8'h25, "R13");
      // R10 time write with SET clear
      sel(8'h00); bus_write(1'b1, 8'h45);
      expect_v(K_TLOAD, 8'h01, "R10");
      @(negedge clk); expect_v(K_TLOAD, 8'h00, "R10");
      rd(1'b1, 8'h45, "R10");
      expect_v(K_TSEC, 8'h45, "R13");
      // R5 SET write
      pulse(3);
      sel(8'h0A); rd(1'b1, 8'hA5, "R5");
      sel(8'h0B); bus_write(1'b1, 8'h9E);
      expect_v(K_CB, 8'h8E, "R5");
      expect_v(K_CA, 8'h25, "R5");
      rd(1'b1, 8'h8E, "R5");
      // R14 uip_set ignored in SET
      pulse(3);
      sel(8'h0A); rd(1'b1, 8'h25, "R14");
      // R10 no reload while SET
      sel(8'h02); bus_write(1'b1, 8'h30);
      expect_v(K_TLOAD, 8'h00, "R10");
      rd(1'b1, 8'h30, "R10");
      expect_v(K_TMIN, 8'h30, "R13");
      // R11 SET exit reloads
      sel(8'h0B); bus_write(1'b1, 8'h02);
      expect_v(K_TLOAD, 8'h01, "R11");
      rd(1'b1, 8'h02, "R11");
      bus_write(1'b1, 8'h02);
      expect_v(K_TLOAD, 8'h00, "R11");
      // R6 C and D read-only
      sel(8'h0C); bus_write(1'b1, 8'hFF);
      expect_v(K_IRQ, 8'h00, "R6");
      rd(1'b1, 8'h00, "R6");
      sel(8'h0D); bus_write(1'b1, 8'h00); rd(1'b1, 8'h80, "R6");
      // R8 flags and held irq
      pulse(0);
      expect_v(K_IRQ, 8'h01, "R8");
      idle(5);
      expect_v(K_IRQ, 8'h01, "R8");
      sel(8'h0C); bus_write(1'b1, 8'h00);
      rd(1'b1, 8'hC0, "R8");
      // R7 clear on read
      expect_v(K_IRQ, 8'h00, "R7");
      rd(1'b1, 8'h00, "R7");
      pulse(2); pulse(1);
      expect_v(K_IRQ, 8'h01, "R8");
      rd(1'b1, 8'hB0, "R8");
      expect_v(K_IRQ, 8'h00, "R7");
      // R9 flag arriving with the C read
      pulse(0);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1; flg_alm = 1'b1;
      expect_v(K_RDATA, 8'hC0, "R9");
      @(negedge clk);
      bus_en = 1'b0; flg_alm = 1'b0;
      expect_v(K_IRQ, 8'h01, "R9");
      rd(1'b1, 8'hA0, "R9");
      expect_v(K_IRQ, 8'h00, "R9");
      idle(2);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule